// File: doc/BRIEF.md
# Modem Status Register with Sticky Change Bits

This block watches four incoming modem handshake lines (carrier detect, ring indicator, data set ready and clear to send). It passes them through a two-flop synchroniser and keeps a recorded copy of their state. Every difference between the synchronised lines and the recorded copy raises a sticky change bit and a change flag for the interrupt logic. The combined byte is presented on a read port. In the upper nibble sit the four line states. In the lower nibble sit the change bits.

A normal read shows the byte and then wipes the change bits, so each read reports changes only once. For self-test, bit 4 of the modem control value selects loopback. In loopback the read port shows a remapped copy of the modem control outputs in place of the recorded lines, and a read leaves the stored change bits alone. The change flag is independent of reads. It is set by any line update and dropped only by its own clear strobe, which the interrupt identification logic drives when it is read.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the read port shows 0xB0 (carrier detect, data set ready and clear to send high; ring low; no change bits), and the change flag is low.
- R2: Bits 7..4 of the read port carry carrier detect, ring indicator, data set ready and clear to send in that order. Bits 3..0 carry delta carrier detect, trailing-edge ring, delta data set ready and delta clear to send in that order.
- R3: Delta carrier detect, delta data set ready and delta clear to send are set when the line differs from its recorded state, in either direction.
- R4: The trailing-edge ring bit (bit 2) is set only when the ring line goes from high to low. A rising ring line leaves it clear.
- R5: Change bits stay set across further line changes until a normal read.
- R6: A read outside loopback (rd_i high for one cycle, mctl_i[4] low) returns the current byte during that cycle. Bits 3..0 are clear from the next cycle.
- R7: A change bit that is raised in the same cycle as a clearing read stays set after the read.
- R8: Any line update sets the change flag. The flag stays high until chg_clr_i is asserted. A line update in the same cycle as the clear leaves the flag high.
- R9: With mctl_i[4] high, the read port shows mctl_i[3] on bit 7, mctl_i[2] on bit 6, mctl_i[0] on bit 5, mctl_i[1] on bit 4, and zero on bits 3..0.
- R10: A read in loopback does not clear the stored change bits. Line changes during loopback are still recorded and become visible once loopback ends.
- R11: A line change driven between clock edges reaches the read port on the third rising edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_dcd_i | input | 1 | Carrier detect line, asynchronous |
| line_ri_i | input | 1 | Ring indicator line, asynchronous |
| line_dsr_i | input | 1 | Data set ready line, asynchronous |
| line_cts_i | input | 1 | Clear to send line, asynchronous |
| mctl_i | input | 5 | Modem control value; bit 4 selects loopback |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | 8 | Status byte (combinational view) |
| chg_o | output | 1 | Modem status changed flag |
| chg_clr_i | input | 1 | Clears the changed flag |

## Verification
The embedded assertions check the following on every cycle:
- Change bits only fall after a clearing read.
- A clearing read with no coincident line update leaves all change bits at zero.
- The trailing-edge ring bit rises only together with a falling recorded ring state.
- The change flag follows every update and holds until it is cleared.

The directed scenarios cover the rest:
- The exact byte values and the bit layout.
- The three-edge synchroniser latency.
- The loopback remap.
- The collision of a change with a read or a flag clear.
- The preservation of change bits across a loopback read.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;

    localparam int NLINE    = 4;
    localparam int MCTL_W   = 5;
    localparam int LOOP_BIT = 4;
    localparam int BYTE_W   = 2 * NLINE;

    // bit order is the register layout: carrier, ring, set ready, clear to send
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    localparam mline_t MLINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    // loopback view of the control outputs
    function automatic logic [BYTE_W-1:0] loop_view(input logic [MCTL_W-1:0] m);
        logic [BYTE_W-1:0] v;
        v      = '0;
        v[7]   = m[3];
        v[6]   = m[2];
        v[5]   = m[0];
        v[4]   = m[1];
        return v;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            hold_q <= meta_q;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import modem_stat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mline_t smp_i,
    input  logic   rd_clr_i,
    output mline_t state_o,
    output mline_t delta_o,
    output logic   upd_o
);
    mline_t st_q, dl_q, diff, set_now;

    always_comb begin
        diff        = st_q ^ smp_i;
        set_now.dcd = diff.dcd;
        set_now.ri  = st_q.ri & ~smp_i.ri;
        set_now.dsr = diff.dsr;
        set_now.cts = diff.cts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= MLINE_RST;
            dl_q <= '0;
        end else begin
            st_q <= smp_i;
            if (rd_clr_i) dl_q <= set_now;
            else          dl_q <= dl_q | set_now;
        end
    end

    assign state_o = st_q;
    assign delta_o = dl_q;
    assign upd_o   = |diff;

    AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_clr_i |=> ((dl_q & $past(dl_q)) == $past(dl_q)));   // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !upd_o) |=> (dl_q == '0));                  // R6
    AST_TERI_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(dl_q[2]) |-> $fell(st_q[2]));                      // R4
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import modem_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_dcd_i,
    input  logic              line_ri_i,
    input  logic              line_dsr_i,
    input  logic              line_cts_i,
    input  logic [MCTL_W-1:0] mctl_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              chg_o,
    input  logic              chg_clr_i
);
    mline_t raw, smp, st, dl;
    logic   upd, loop_en, rd_clr, chg_q;

    assign raw     = '{dcd: line_dcd_i, ri: line_ri_i, dsr: line_dsr_i, cts: line_cts_i};
    assign loop_en = mctl_i[LOOP_BIT];
    assign rd_clr  = rd_i & ~loop_en;

    msr_sync #(.W(NLINE), .RST_VAL(MLINE_RST)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw), .sync_o(smp)
    );

    msr_delta u_delta (
        .clk(clk), .rst(rst), .smp_i(smp), .rd_clr_i(rd_clr),
        .state_o(st), .delta_o(dl), .upd_o(upd)
    );

    always_ff @(posedge clk) begin
        if (rst)            chg_q <= 1'b0;
        else if (upd)       chg_q <= 1'b1;
        else if (chg_clr_i) chg_q <= 1'b0;
    end

    assign rd_data_o = loop_en ? loop_view(mctl_i) : {st, dl};
    assign chg_o     = chg_q;

    AST_CHG_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        upd |=> chg_o);                                          // R8
    AST_CHG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (chg_o && !chg_clr_i) |=> chg_o);                        // R8
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dcd = 1'b1, ri = 1'b0, dsr = 1'b1, cts = 1'b1;
    logic [4:0] mctl = '0;
    logic       rd = 1'b0, clr = 1'b0;
    logic [7:0] dout;
    logic       chg;
    int         total = 0, bad = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    modem_status_reg u_dut (
        .clk(clk), .rst(rst), .line_dcd_i(dcd), .line_ri_i(ri),
        .line_dsr_i(dsr), .line_cts_i(cts), .mctl_i(mctl), .rd_i(rd),
        .rd_data_o(dout), .chg_o(chg), .chg_clr_i(clr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        rd = 1'b1;
        #1 v = dout;
        @(negedge clk);
        rd = 1'b0;
        #1;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 reset byte", dout, 8'hB0);
        chk("R1 reset flag", {7'd0, chg}, 8'h00);
    endtask

    task automatic t_latency_cts();
        @(negedge clk) cts = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not before third edge", dout, 8'hB0);
        @(posedge clk);
        @(negedge clk);
        chk("R11/R3 cts fall", dout, 8'hA1);
        chk("R8 flag set", {7'd0, chg}, 8'h01);
        pulse_clr();
        chk("R8 flag cleared", {7'd0, chg}, 8'h00);
    endtask

    task automatic t_read_clear();
        do_read(got);
        chk("R6 read value", got, 8'hA1);
        chk("R6 deltas cleared", dout, 8'hA0);
    endtask

    task automatic t_sticky_dsr();
        @(negedge clk) dsr = 1'b0;
        settle();
        chk("R3 dsr fall", dout, 8'h82);
        @(negedge clk) dsr = 1'b1;
        settle();
        chk("R5 delta sticks across rise", dout, 8'hA2);
        do_read(got);
        chk("R5 read sees sticky", got, 8'hA2);
        chk("R6 cleared", dout, 8'hA0);
    endtask

    task automatic t_ring();
        @(negedge clk) ri = 1'b1;
        settle();
        chk("R4 rising ring no edge bit", dout, 8'hE0);
        @(negedge clk) ri = 1'b0;
        settle();
        chk("R4 trailing ring edge", dout, 8'hA4);
        do_read(got);
        chk("R2 layout after read", dout, 8'hA0);
    endtask

    task automatic t_carrier();
        @(negedge clk) dcd = 1'b0;
        settle();
        chk("R3 dcd fall", dout, 8'h28);
        @(negedge clk) dcd = 1'b1;
        settle();
        chk("R3 dcd rise", dout, 8'hA8);
        do_read(got);
        chk("R2 idle byte", dout, 8'hA0);
    endtask

    task automatic t_collide();
        pulse_clr();
        @(negedge clk) cts = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd = 1'b1;
        clr = 1'b1;
        #1 got = dout;
        @(negedge clk);
        rd = 1'b0;
        clr = 1'b0;
        #1;
        chk("R7 read before update", got, 8'hA0);
        chk("R7 delta kept", dout, 8'hB1);
        chk("R8 flag survives clear", {7'd0, chg}, 8'h01);
        do_read(got);
        chk("R6 cleared", dout, 8'hB0);
        pulse_clr();
    endtask

    task automatic t_loop();
        @(negedge clk) mctl = 5'b10110;
        #1 chk("R9 remap a", dout, 8'h50);
        @(negedge clk) cts = 1'b0;
        settle();
        chk("R10 loop hides lines", dout, 8'h50);
        do_read(got);
        chk("R9 loop read", got, 8'h50);
        @(negedge clk) mctl = 5'b11001;
        #1 chk("R9 remap b", dout, 8'hA0);
        @(negedge clk) mctl = 5'b00000;
        #1 chk("R10 delta kept through loop read", dout, 8'hA1);
        do_read(got);
        chk("R6 normal read after loop", dout, 8'hA0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        t_reset();
        t_latency_cts();
        t_read_clear();
        t_sticky_dsr();
        t_ring();
        t_carrier();
        t_collide();
        t_loop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule